// File: doc/BRIEF.md
# Processor Bus Region Router with Page Copy Engine

This block sits between an 8-bit processor's 16-bit address bus and the targets behind it. The top three address bits pick one of eight 8 KiB windows. The block holds the 2 KiB work RAM, which repeats four times across the lowest window. It passes save-RAM and program-ROM accesses to one external memory port, tagged with the window number. Accesses to the video-register and I/O windows go out as simple strobes. Writes into the four ROM windows are never stored; they leave on a separate mapper-write strobe that carries the full address and data.

A write of a page number to I/O offset 0x14 loads a shadow register and starts a copy of one 256-byte page into an internal 256-byte object-attribute memory. The top three bits of the page number choose the source: work RAM, save RAM or one of the ROM slots. The copy moves one byte per clock, and the stall output stays high for the whole copy. The video side reads the object-attribute memory through its own registered read port. All processor reads return data on the cycle after the request.

Top module: `bus_region_router`

## Requirements
- R1: Window 0 (addr[15:13]=0) is a 2 KiB work RAM indexed by addr[10:0], so 0x0800-0x1FFF alias 0x0000-0x07FF.
- R2: A read accepted in cycle N presents its data on cpu_rdata in cycle N+1. The external, video and I/O targets must also answer in cycle N+1.
- R3: Window 3 (0x6000-0x7FFF) maps to the external port with ext_sel=3 and ext_addr=addr[12:0]. Reads raise ext_rd and writes raise ext_we, in the same cycle as the request.
- R4: Windows 4-7 read the external port with ext_sel=addr[15:13] (ROM slots 0-3) and ext_addr=addr[12:0]. A write to them raises map_we with map_addr=the full address and map_wdata=the data, and never ext_we.
- R5: A write anywhere in 0x2000-0x3FFF raises vid_we with vid_reg=addr[2:0]. Only 0x2000-0x2007 raise vid_rd. Other reads in the window return 0x00 and raise no strobe.
- R6: In window 2, offsets 0x00-0x17 other than 0x14 reach the I/O port with io_addr=addr[4:0]. Reads at offsets 0x18-0x1FFF return 0x00, and writes there raise no strobe.
- R7: A write to 0x4014 loads the shadow register and raises no I/O strobe. A read of 0x4014 returns the shadow.
- R8: The copy source for page byte P is chosen by P[7:5]. A value of 0 reads work RAM at ({P,8'h00} & 0x7FF)+i. A value of 3 or 4-7 reads the external port with ext_sel=P[7:5] and ext_addr={P[4:0], i}.
- R9: After an accepted trigger in cycle T, stall is high from cycle T+1 for exactly 257 cycles. Object memory entries 0 to 255 are written in ascending order, entry i receiving source byte i.
- R10: A trigger whose P[7:5] is 1 or 2 updates the shadow only. Stall stays low and the object memory is unchanged.
- R11: While stall is high, cpu_rd and cpu_wr are ignored: no store, no strobe, no mapper write.
- R12: oam_rdata shows object memory entry oam_raddr one cycle after oam_raddr is applied.
- R13: After reset, stall is low, cpu_rdata is 0x00 and the shadow register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request (takes priority over cpu_rd) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after the request |
| stall | output | 1 | Copy in progress; processor requests are dropped |
| ext_rd | output | 1 | External save-RAM/ROM read strobe |
| ext_we | output | 1 | External save-RAM write strobe |
| ext_sel | output | 3 | Window number for the external access (3 = save RAM, 4-7 = ROM slots) |
| ext_addr | output | 13 | Offset within the window |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data, due the cycle after ext_rd |
| map_we | output | 1 | Mapper write strobe |
| map_addr | output | 16 | Mapper write address |
| map_wdata | output | 8 | Mapper write data |
| vid_rd | output | 1 | Video register read strobe |
| vid_we | output | 1 | Video register write strobe |
| vid_reg | output | 3 | Video register number |
| vid_wdata | output | 8 | Video register write data |
| vid_rdata | input | 8 | Video register data, due the cycle after vid_rd |
| io_rd | output | 1 | I/O read strobe |
| io_we | output | 1 | I/O write strobe |
| io_addr | output | 5 | I/O register offset |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data, due the cycle after io_rd |
| oam_raddr | input | 8 | Object memory read address |
| oam_rdata | output | 8 | Object memory read data, one cycle later |

## Verification
The bench probes strobes and external addresses 2 ns after it drives a request, because they are combinational in the request cycle. Processor read data is due one edge later. The driver queues the expected byte, and a monitor pops it at the falling edge after the accepting edge. Stall is sampled at every falling edge after a trigger and must read high exactly 257 times. The object memory is then swept through its read port, each entry sampled one cycle after its address is applied.

// File: rtl/bus_region_router.sv
module bus_region_router #(
  parameter int WRAM_AW = 11,
  parameter logic [4:0] TRIG_OFS = 5'h14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        stall,
  output logic        ext_rd,
  output logic        ext_we,
  output logic [2:0]  ext_sel,
  output logic [12:0] ext_addr,
  output logic [7:0]  ext_wdata,
  input  logic [7:0]  ext_rdata,
  output logic        map_we,
  output logic [15:0] map_addr,
  output logic [7:0]  map_wdata,
  output logic        vid_rd,
  output logic        vid_we,
  output logic [2:0]  vid_reg,
  output logic [7:0]  vid_wdata,
  input  logic [7:0]  vid_rdata,
  output logic        io_rd,
  output logic        io_we,
  output logic [4:0]  io_addr,
  output logic [7:0]  io_wdata,
  input  logic [7:0]  io_rdata,
  input  logic [7:0]  oam_raddr,
  output logic [7:0]  oam_rdata
);
  localparam int WRAM_D = 1 << WRAM_AW;
  localparam logic [2:0] S_ZERO = 3'd0, S_WRAM = 3'd1, S_EXT = 3'd2,
                         S_VID = 3'd3, S_IO = 3'd4, S_SHD = 3'd5;

  logic [7:0] wram [WRAM_D];
  logic [7:0] oam [256];
  logic [7:0] wram_q, shadow, page, wr_idx;
  logic [8:0] rd_cnt;
  logic       busy, wr_pend;
  logic [2:0] rsrc;

  wire [2:0] region = cpu_addr[15:13];
  wire rd_ok   = cpu_rd & ~cpu_wr & ~busy;
  wire wr_ok   = cpu_wr & ~busy;
  wire is_wram = region == 3'd0;
  wire is_vid  = region == 3'd1;
  wire is_io   = region == 3'd2;
  wire is_sram = region == 3'd3;
  wire is_rom  = cpu_addr[15];
  wire vid_low = cpu_addr[12:3] == 10'd0;
  wire io_map  = (cpu_addr[12:5] == 8'd0) && (cpu_addr[4:3] != 2'b11);
  wire io_trig = io_map && (cpu_addr[4:0] == TRIG_OFS);
  wire trig_go = wr_ok & is_io & io_trig;
  wire trig_ok = (cpu_wdata[7:5] != 3'd1) && (cpu_wdata[7:5] != 3'd2);
  wire dma_issue = busy & ~rd_cnt[8];
  wire dma_ext   = page[7:5] != 3'd0;

  wire [WRAM_AW-1:0] wram_raddr =
    busy ? {page[WRAM_AW-9:0], rd_cnt[7:0]} : cpu_addr[WRAM_AW-1:0];

  assign stall     = busy;
  assign ext_rd    = busy ? (dma_issue & dma_ext) : (rd_ok & (is_sram | is_rom));
  assign ext_sel   = busy ? page[7:5] : region;
  assign ext_addr  = busy ? {page[4:0], rd_cnt[7:0]} : cpu_addr[12:0];
  assign ext_we    = wr_ok & is_sram;
  assign ext_wdata = cpu_wdata;
  assign map_we    = wr_ok & is_rom;
  assign map_addr  = cpu_addr;
  assign map_wdata = cpu_wdata;
  assign vid_we    = wr_ok & is_vid;
  assign vid_rd    = rd_ok & is_vid & vid_low;
  assign vid_reg   = cpu_addr[2:0];
  assign vid_wdata = cpu_wdata;
  assign io_we     = wr_ok & is_io & io_map & ~io_trig;
  assign io_rd     = rd_ok & is_io & io_map & ~io_trig;
  assign io_addr   = cpu_addr[4:0];
  assign io_wdata  = cpu_wdata;

  always_ff @(posedge clk) begin
    if (wr_ok && is_wram) wram[cpu_addr[WRAM_AW-1:0]] <= cpu_wdata;
    wram_q <= wram[wram_raddr];
  end

  always_ff @(posedge clk) begin
    if (wr_pend) oam[wr_idx] <= dma_ext ? ext_rdata : wram_q;
    oam_rdata <= oam[oam_raddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_cnt  <= 9'd0;
      wr_pend <= 1'b0;
      wr_idx  <= 8'd0;
      page    <= 8'd0;
      shadow  <= 8'd0;
      rsrc    <= S_ZERO;
    end else begin
      if (trig_go) begin
        shadow <= cpu_wdata;
        page   <= cpu_wdata;
        if (trig_ok) begin
          busy   <= 1'b1;
          rd_cnt <= 9'd0;
        end
      end
      if (dma_issue) rd_cnt <= rd_cnt + 9'd1;
      wr_pend <= dma_issue;
      wr_idx  <= rd_cnt[7:0];
      if (wr_pend && wr_idx == 8'hFF) busy <= 1'b0;
      if (rd_ok) begin
        if (is_wram)                rsrc <= S_WRAM;
        else if (is_sram || is_rom) rsrc <= S_EXT;
        else if (is_vid)            rsrc <= vid_low ? S_VID : S_ZERO;
        else if (io_trig)           rsrc <= S_SHD;
        else                        rsrc <= io_map ? S_IO : S_ZERO;
      end
    end
  end

  always_comb begin
    case (rsrc)
      S_WRAM:  cpu_rdata = wram_q;
      S_EXT:   cpu_rdata = ext_rdata;
      S_VID:   cpu_rdata = vid_rdata;
      S_IO:    cpu_rdata = io_rdata;
      S_SHD:   cpu_rdata = shadow;
      default: cpu_rdata = 8'h00;
    endcase
  end
endmodule

module router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stall,
  input logic        cpu_wr,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        map_we,
  input logic        ext_we,
  input logic        ext_rd,
  input logic [2:0]  ext_sel,
  input logic [7:0]  page,
  input logic        vid_we,
  input logic        vid_rd,
  input logic        io_we,
  input logic        io_rd,
  input logic        wr_pend,
  input logic [7:0]  wr_idx
);
  logic [8:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= 9'd0;
    else run <= stall ? run + 9'd1 : 9'd0;
  end

  // R9
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> run <= 9'd256);
  // R9
  stall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && run == 9'd256) |=> !stall);
  // R9
  oam_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && $past(wr_pend)) |-> wr_idx == $past(wr_idx) + 8'd1);
  // R11
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !(map_we || ext_we || vid_we || vid_rd || io_we || io_rd));
  // R4
  rom_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> !ext_we);
  // R10
  bad_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !stall && cpu_addr == 16'h4014 &&
     (cpu_wdata[7:5] == 3'd1 || cpu_wdata[7:5] == 3'd2)) |=> !stall);
  // R8
  dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && ext_rd) |-> (ext_sel == page[7:5] && page[7:5] >= 3'd3));
endmodule

bind bus_region_router router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .cpu_wr(cpu_wr),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .map_we(map_we),
  .ext_we(ext_we), .ext_rd(ext_rd), .ext_sel(ext_sel), .page(page),
  .vid_we(vid_we), .vid_rd(vid_rd), .io_we(io_we), .io_rd(io_rd),
  .wr_pend(wr_pend), .wr_idx(wr_idx)
);

// File: tb/test_bus_region_router.sv
`timescale 1ns/1ps
module test_bus_region_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0, oam_raddr = '0;
  logic [7:0] cpu_rdata, oam_rdata, map_wdata, ext_wdata, vid_wdata, io_wdata;
  logic stall, ext_rd, ext_we, map_we, vid_rd, vid_we, io_rd, io_we;
  logic [2:0] ext_sel, vid_reg;
  logic [12:0] ext_addr;
  logic [15:0] map_addr;
  logic [4:0] io_addr;
  logic [7:0] ext_rdata = '0, vid_rdata = '0, io_rdata = '0;

  always #10 clk = ~clk;

  bus_region_router i_bus_region_router (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .stall(stall), .ext_rd(ext_rd), .ext_we(ext_we), .ext_sel(ext_sel),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .map_we(map_we), .map_addr(map_addr), .map_wdata(map_wdata),
    .vid_rd(vid_rd), .vid_we(vid_we), .vid_reg(vid_reg),
    .vid_wdata(vid_wdata), .vid_rdata(vid_rdata), .io_rd(io_rd),
    .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .oam_raddr(oam_raddr), .oam_rdata(oam_rdata));

  function automatic logic [7:0] ext_f(input logic [2:0] s, input logic [12:0] a);
    return {s, 5'b0} ^ a[7:0] ^ {3'b0, a[12:8]} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (ext_rd) ext_rdata <= ext_f(ext_sel, ext_addr);
    if (vid_rd) vid_rdata <= 8'hB0 | {5'b0, vid_reg};
    if (io_rd)  io_rdata  <= 8'h40 + {3'b0, io_addr};
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  logic [7:0] exp_q[$];
  string tag_q[$];
  logic acc_q = 1'b0;
  always @(posedge clk) acc_q <= rst_n & cpu_rd & ~cpu_wr & ~stall;
  always @(negedge clk) if (acc_q && exp_q.size() > 0) begin
    logic [7:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(cpu_rdata == e, t, cpu_rdata, e);
  end

  logic p_ext_rd, p_ext_we, p_map_we, p_vid_rd, p_vid_we, p_io_rd, p_io_we;
  logic [2:0] p_ext_sel, p_vid_reg;
  logic [12:0] p_ext_addr;
  logic [15:0] p_map_addr;
  logic [7:0] p_map_wdata;
  logic [4:0] p_io_addr;
  task automatic snap();
    #2;
    p_ext_rd = ext_rd; p_ext_we = ext_we; p_map_we = map_we;
    p_vid_rd = vid_rd; p_vid_we = vid_we; p_io_rd = io_rd; p_io_we = io_we;
    p_ext_sel = ext_sel; p_vid_reg = vid_reg; p_ext_addr = ext_addr;
    p_map_addr = map_addr; p_map_wdata = map_wdata; p_io_addr = io_addr;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    snap();
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [15:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    snap();
    @(negedge clk);
    cpu_rd = 1'b0;
    @(negedge clk);
  endtask

  logic [7:0] wexp [256];
  task automatic sweep_oam(input logic [7:0] pg, input string t);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] e;
      @(negedge clk);
      oam_raddr = i[7:0];
      e = (pg[7:5] == 3'd0) ? wexp[i] : ext_f(pg[7:5], {pg[4:0], i[7:0]});
      @(negedge clk);
      chk(oam_rdata == e, t, oam_rdata, e);
    end
  endtask

  task automatic trigger_and_time(input logic [7:0] pg, input bit poke);
    int n;
    cpu_write(16'h4014, pg);
    chk(p_io_we == 1'b0, "R7 trigger raises no io_we", p_io_we, 0);
    n = 0;
    while (stall && n < 400) begin
      n++;
      if (poke && n == 10) begin
        cpu_addr = 16'h0010; cpu_wdata = 8'h77; cpu_wr = 1'b1;
      end
      if (poke && n == 11) begin
        cpu_addr = 16'h8000; cpu_wdata = 8'h99; cpu_wr = 1'b1;
        #2;
        chk(map_we == 1'b0, "R11 mapper write during stall", map_we, 0);
      end
      if (poke && n == 12) begin
        cpu_addr = 16'h2002; cpu_wr = 1'b0; cpu_rd = 1'b1;
        #2;
        chk(vid_rd == 1'b0, "R11 video read during stall", vid_rd, 0);
      end
      if (poke && n == 13) cpu_rd = 1'b0;
      @(negedge clk);
    end
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    chk(n == 257, "R9 stall length", n, 257);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stall == 1'b0, "R13 stall after reset", stall, 0);
    chk(cpu_rdata == 8'h00, "R13 rdata after reset", cpu_rdata, 0);
    cpu_read(16'h4014, 8'h00, "R13 shadow after reset");

    cpu_write(16'h0123, 8'hA5);
    cpu_read(16'h0923, 8'hA5, "R1 mirror 0x0923");
    cpu_read(16'h1923, 8'hA5, "R1 mirror 0x1923");
    cpu_write(16'h0010, 8'h11);
    cpu_read(16'h0010, 8'h11, "R2 work RAM read next cycle");

    cpu_write(16'h6ABC, 8'h5E);
    chk(p_ext_we && p_ext_sel == 3'd3 && p_ext_addr == 13'h0ABC,
        "R3 save RAM write strobe", {p_ext_we, p_ext_sel, p_ext_addr}, {1'b1, 3'd3, 13'h0ABC});
    cpu_read(16'h7FFF, ext_f(3'd3, 13'h1FFF), "R3 save RAM read");
    chk(p_ext_rd && p_ext_sel == 3'd3 && p_ext_addr == 13'h1FFF,
        "R3 save RAM read strobe", {p_ext_rd, p_ext_sel, p_ext_addr}, {1'b1, 3'd3, 13'h1FFF});

    cpu_write(16'hC123, 8'h42);
    chk(p_map_we && !p_ext_we && p_map_addr == 16'hC123 && p_map_wdata == 8'h42,
        "R4 ROM write to mapper", {p_map_we, p_ext_we, p_map_addr, p_map_wdata},
        {1'b1, 1'b0, 16'hC123, 8'h42});
    cpu_read(16'hE456, ext_f(3'd7, 13'h0456), "R4 ROM slot 3 read");
    chk(p_ext_rd && p_ext_sel == 3'd7 && p_ext_addr == 13'h0456,
        "R4 ROM read strobe", {p_ext_rd, p_ext_sel, p_ext_addr}, {1'b1, 3'd7, 13'h0456});
    cpu_read(16'h8001, ext_f(3'd4, 13'h0001), "R4 ROM slot 0 read");

    cpu_write(16'h3FFD, 8'h10);
    chk(p_vid_we && p_vid_reg == 3'd5, "R5 video write mirror", {p_vid_we, p_vid_reg}, {1'b1, 3'd5});
    cpu_read(16'h2002, 8'hB2, "R5 video read");
    cpu_read(16'h2008, 8'h00, "R5 video unmapped read");
    chk(p_vid_rd == 1'b0, "R5 no strobe on unmapped read", p_vid_rd, 0);

    cpu_read(16'h4015, 8'h55, "R6 io read");
    chk(p_io_rd && p_io_addr == 5'h15, "R6 io read strobe", {p_io_rd, p_io_addr}, {1'b1, 5'h15});
    cpu_read(16'h4018, 8'h00, "R6 io unmapped 0x4018");
    cpu_read(16'h5000, 8'h00, "R6 io unmapped 0x5000");
    cpu_write(16'h4016, 8'h01);
    chk(p_io_we && p_io_addr == 5'h16, "R6 io write strobe", {p_io_we, p_io_addr}, {1'b1, 5'h16});
    cpu_write(16'h4020, 8'h01);
    chk(p_io_we == 1'b0, "R6 io unmapped write", p_io_we, 0);

    trigger_and_time(8'hA7, 1'b1);
    cpu_read(16'h0010, 8'h11, "R11 work RAM write during stall dropped");
    cpu_read(16'h4014, 8'hA7, "R7 shadow readback");
    chk(p_io_rd == 1'b0, "R7 shadow read raises no io_rd", p_io_rd, 0);
    sweep_oam(8'hA7, "R8 R9 R12 ROM slot 1 page copy");

    trigger_and_time(8'h7F, 1'b0);
    sweep_oam(8'h7F, "R8 R9 save RAM page copy");

    cpu_write(16'h4014, 8'h25);
    for (int k = 0; k < 5; k++) begin
      chk(stall == 1'b0, "R10 no stall on unsupported region", stall, 0);
      @(negedge clk);
    end
    cpu_read(16'h4014, 8'h25, "R10 shadow still updated");
    sweep_oam(8'h7F, "R10 object memory unchanged");

    for (int i = 0; i < 256; i++) begin
      wexp[i] = i[7:0] ^ 8'h5A;
      cpu_write(16'h0300 + 16'(i), wexp[i]);
    end
    trigger_and_time(8'h0B, 1'b0);
    sweep_oam(8'h0B, "R8 work RAM page copy with mask");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule